// File: doc/BRIEF.md
# Configuration Status Register with Error Latching

This block holds the 16-bit status word of a host-controller function's configuration header. Most bits are fixed capability indications. Four bits are sticky error flags, which are set by internal events and cleared by software writing ones. One bit is a live view of the function's raw interrupt level. Software reaches the word through a small configuration port. The port has a select, a write strobe, two byte enables and write data. A combinational read-back path returns the word while the register is selected.

Two control bits come in from the companion command register. One enables system-error signalling and the other enables parity-error response. A received master abort or target abort on a memory access counts as a host error. Such an error latches its own flag and raises a halt line for the DMA engines, and that line stays high until reset. The block also emits a one-cycle system-error request for each cycle in which an enabled system-error condition occurs.

Top module: `cfg_status_reg`

## Requirements
- R1: After reset the word reads 0x0290 (with the interrupt input low). Bits 15, 11, 6, 5 and 2:0 always read 0. Bits 7 and 4 always read 1. Bits 10:9 always read the DEVSEL timing value 01. Writes never change any of these bits.
- R2: Bits 14, 13, 12 and 8 are write-1-to-clear. A write that is selected and has byte enable bit 1 set clears each of these flags whose write-data bit is 1. A write-data bit of 0 leaves its flag unchanged. A write with byte enable bit 1 clear changes nothing.
- R3: Bit 14 sets at the clock edge that samples an enabled system-error condition. The condition is an internal SERR event, a master abort or a target abort, each counted only while the SERR-enable input is 1.
- R4: Bit 13 sets at the edge that samples a master-abort event, and bit 12 sets at the edge that samples a target-abort event. Neither depends on the command inputs.
- R5: `dma_halt` rises at the edge that samples a master or target abort. It then stays 1 until reset, and writes have no effect on it.
- R6: `serr_req` is 1 for exactly the cycle after each cycle with an enabled system-error condition, as defined in R3. It is never 1 after a cycle in which the SERR-enable input is 0.
- R7: Bit 8 sets at the edge that samples a read-completion parity error, but only while the parity-response input is 1.
- R8: Bit 3 equals `irq_raw` in the same cycle, whatever the enables or writes do.
- R9: When a flag's set event and a write-1-to-clear of that flag fall in the same cycle, the flag ends up set.
- R10: `cfg_rdata` equals `stat_value` while `cfg_sel` is 1, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 1 | Configuration access addresses this register |
| cfg_wr | input | 1 | Write strobe |
| cfg_be | input | 2 | Byte enables (bit 1 = upper byte) |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read-back data |
| ev_serr | input | 1 | Internal system-error event |
| ev_master_abort | input | 1 | Master abort received on a memory access |
| ev_target_abort | input | 1 | Target abort received on a memory access |
| ev_rd_parity | input | 1 | Data parity error on a read completion |
| irq_raw | input | 1 | Raw interrupt level, before enable |
| cmd_serr_en | input | 1 | SERR enable from the command register |
| cmd_perr_resp | input | 1 | Parity-error response enable from the command register |
| stat_value | output | 16 | Current status word |
| dma_halt | output | 1 | Host-error halt for the DMA engines |
| serr_req | output | 1 | One-cycle system-error request |

## Verification
The assertions check on every cycle that:
- an abort always produces the halt on the next edge, and the halt never drops;
- no SERR request follows a cycle with SERR disabled;
- an event sets its flag even when a clear arrives in the same cycle;
- an unopposed clear empties a flag;
- a set flag stays set without a clear;
- the interrupt bit tracks its input.

Only the bench's scenarios can show the following. The full status word matches across a sweep of every event, enable and write combination. The fixed bits survive arbitrary writes. Byte-enable gating and zero-bit writes leave flags intact. The read path returns zero when the register is not selected.

// File: rtl/cfg_status_reg.sv
module cfg_status_reg #(
  parameter logic [1:0] DEVSEL_TIMING = 2'b01
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_sel,
  input  logic        cfg_wr,
  input  logic [1:0]  cfg_be,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic        ev_serr,
  input  logic        ev_master_abort,
  input  logic        ev_target_abort,
  input  logic        ev_rd_parity,
  input  logic        irq_raw,
  input  logic        cmd_serr_en,
  input  logic        cmd_perr_resp,
  output logic [15:0] stat_value,
  output logic        dma_halt,
  output logic        serr_req
);

  logic sys_err_q, m_abort_q, t_abort_q, par_err_q, halt_q, sreq_q;

  wire upper_wr  = cfg_sel & cfg_wr & cfg_be[1];
  wire serr_fire = cmd_serr_en & (ev_serr | ev_master_abort | ev_target_abort);
  wire par_fire  = cmd_perr_resp & ev_rd_parity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_err_q <= 1'b0;
      m_abort_q <= 1'b0;
      t_abort_q <= 1'b0;
      par_err_q <= 1'b0;
      halt_q    <= 1'b0;
      sreq_q    <= 1'b0;
    end else begin
      sys_err_q <= (sys_err_q & ~(upper_wr & cfg_wdata[14])) | serr_fire;
      m_abort_q <= (m_abort_q & ~(upper_wr & cfg_wdata[13])) | ev_master_abort;
      t_abort_q <= (t_abort_q & ~(upper_wr & cfg_wdata[12])) | ev_target_abort;
      par_err_q <= (par_err_q & ~(upper_wr & cfg_wdata[8]))  | par_fire;
      halt_q    <= halt_q | ev_master_abort | ev_target_abort;
      sreq_q    <= serr_fire;
    end
  end

  assign stat_value = {1'b0, sys_err_q, m_abort_q, t_abort_q, 1'b0, DEVSEL_TIMING,
                       par_err_q, 1'b1, 2'b00, 1'b1, irq_raw, 3'b000};
  assign cfg_rdata  = cfg_sel ? stat_value : 16'h0000;
  assign dma_halt   = halt_q;
  assign serr_req   = sreq_q;

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[15], cfg_wdata[11:9], cfg_wdata[7:0], cfg_be[0]};

endmodule

module cfg_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_sel,
  input logic        cfg_wr,
  input logic [1:0]  cfg_be,
  input logic [15:0] cfg_wdata,
  input logic        ev_master_abort,
  input logic        ev_target_abort,
  input logic        irq_raw,
  input logic        cmd_serr_en,
  input logic [15:0] stat_value,
  input logic        dma_halt,
  input logic        serr_req
);
  wire clr13 = cfg_sel & cfg_wr & cfg_be[1] & cfg_wdata[13];

  // R5
  abort_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_master_abort | ev_target_abort) |=> dma_halt);
  // R5
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_halt |=> dma_halt);
  // R6
  serr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_serr_en |=> !serr_req);
  // R9
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_master_abort |=> stat_value[13]);
  // R2
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr13 && !ev_master_abort) |=> !stat_value[13]);
  // R4
  flag_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_value[13] && !clr13) |=> stat_value[13]);
  // R8
  irq_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_value[3] == irq_raw);
endmodule

bind cfg_status_reg cfg_status_reg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
  .cfg_wdata(cfg_wdata), .ev_master_abort(ev_master_abort),
  .ev_target_abort(ev_target_abort), .irq_raw(irq_raw), .cmd_serr_en(cmd_serr_en),
  .stat_value(stat_value), .dma_halt(dma_halt), .serr_req(serr_req)
);

// File: tb/tb_cfg_status_reg.sv
module tb_cfg_status_reg;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_sel = 0, cfg_wr = 0;
  logic [1:0] cfg_be = 0;
  logic [15:0] cfg_wdata = 0;
  logic ev_serr = 0, ev_ma = 0, ev_ta = 0, ev_par = 0, irq = 0, s_en = 0, p_en = 0;
  logic [15:0] cfg_rdata, stat_value;
  logic dma_halt, serr_req;

  int checks = 0, errors = 0;
  logic m14, m13, m12, m8, mhalt, msreq;

  always #(PERIOD/2) clk = ~clk;

  cfg_status_reg dut (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ev_serr(ev_serr),
    .ev_master_abort(ev_ma), .ev_target_abort(ev_ta), .ev_rd_parity(ev_par),
    .irq_raw(irq), .cmd_serr_en(s_en), .cmd_perr_resp(p_en),
    .stat_value(stat_value), .dma_halt(dma_halt), .serr_req(serr_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word();
    return {1'b0, m14, m13, m12, 1'b0, 2'b01, m8, 1'b1, 2'b00, 1'b1, irq, 3'b000};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    {cfg_sel, cfg_wr, cfg_be, cfg_wdata} = '0;
    {ev_serr, ev_ma, ev_ta, ev_par, irq, s_en, p_en} = '0;
    {m14, m13, m12, m8, mhalt, msreq} = '0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // apply inputs at a negedge, let one posedge pass, update model, check at next negedge
  task automatic step();
    logic [15:0] clr;
    logic sf;
    #1;
    chk("R8 irq bit", {15'd0, stat_value[3]}, {15'd0, irq});
    chk("R10 read path", cfg_rdata, cfg_sel ? stat_value : 16'h0);
    clr = (cfg_sel & cfg_wr & cfg_be[1]) ? cfg_wdata : 16'h0;
    sf  = s_en & (ev_serr | ev_ma | ev_ta);
    @(posedge clk);
    m14 = (m14 & ~clr[14]) | sf;
    m13 = (m13 & ~clr[13]) | ev_ma;
    m12 = (m12 & ~clr[12]) | ev_ta;
    m8  = (m8  & ~clr[8])  | (p_en & ev_par);
    mhalt = mhalt | ev_ma | ev_ta;
    msreq = sf;
    @(negedge clk);
    chk("R1 fixed bits", stat_value & 16'h8EF7, exp_word() & 16'h8EF7);
    chk("R3 bit14", {15'd0, stat_value[14]}, {15'd0, m14});
    chk("R4 bit13", {15'd0, stat_value[13]}, {15'd0, m13});
    chk("R4 bit12", {15'd0, stat_value[12]}, {15'd0, m12});
    chk("R7 bit8",  {15'd0, stat_value[8]},  {15'd0, m8});
    chk("R5 halt",  {15'd0, dma_halt}, {15'd0, mhalt});
    chk("R6 serr_req", {15'd0, serr_req}, {15'd0, msreq});
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset value
    #1 chk("R1 reset value", stat_value, 16'h0290);
    chk("R5 halt after reset", {15'd0, dma_halt}, 16'h0);

    // R2 directed: set bit13, then writes with be1=0, zero bit, then one
    @(negedge clk); ev_ma = 1; step(); ev_ma = 0;
    cfg_sel = 1; cfg_wr = 1; cfg_be = 2'b01; cfg_wdata = 16'hFFFF; step();
    chk("R2 be1 clear ignored", {15'd0, stat_value[13]}, 16'h1);
    cfg_be = 2'b10; cfg_wdata = 16'hDFFF & 16'h0000; step();
    chk("R2 zero write ignored", {15'd0, stat_value[13]}, 16'h1);
    // R9: clear and event together
    cfg_wdata = 16'h2000; ev_ma = 1; step();
    chk("R9 set wins", {15'd0, stat_value[13]}, 16'h1);
    ev_ma = 0; step();
    chk("R2 clear", {15'd0, stat_value[13]}, 16'h0);
    chk("R5 halt kept after writes", {15'd0, dma_halt}, 16'h1);
    cfg_sel = 0; cfg_wr = 0;

    // sweep over events, enables and write patterns
    for (int i = 0; i < 4096; i++) begin
      if (i % 64 == 0) do_reset();
      {ev_serr, ev_ma, ev_ta, ev_par, irq, s_en, p_en} = 7'(i >> (i % 3));
      if ((i % 5) < 3) {ev_ma, ev_ta} = 2'b00;
      cfg_sel   = i[7];
      cfg_wr    = i[8];
      cfg_be    = {i[9], i[10]};
      cfg_wdata = 16'(i * 16'h9E37) ^ 16'(i >> 3);
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule